// File: doc/BRIEF.md
# Dual-Clock Parity RAM

This block is a two-port memory with one write port and one read port. Each port runs from its own clock. Every stored word carries one extra parity bit. Three compile-time choices shape it:

- **Read timing.** The read port can be purely combinational, address-registered (transparent), or fully pipelined.
- **Write timing.** The write port can capture on its clock, or capture on the rising edge of its active-low strobe.
- **Parity.** A parity mode makes the block either generate parity for each written word, or check a parity bit supplied by the writer. In check modes it reports a mismatch on the write side and again on the read side.

It is meant as a storage element between two clock domains, for example as the array under a FIFO or a lookup buffer. The parity bit follows the word through the array, so a fault introduced in storage is seen when the word is read back.

Top module: `dcram_par`

## Requirements
- R1: With WR_MODE=0 (synchronous), a rising `wclk` with `wr_n`=0 stores `wdata`, with its parity bit, at `waddr`. A rising `wclk` with `wr_n`=1 leaves every word unchanged.
- R2: With RD_MODE=1 (transparent), a rising `rclk` with `rd_n`=0 loads `raddr` into an address register. `rdata` then shows the word at that address, including any later write to it. With `rd_n`=1 the address register holds.
- R3: With RD_MODE=2 (pipelined), the word chosen by a read edge appears on `rdata`, `rpar` and `rd_perr` one `rclk` edge later. Two edges after any edge sampled with `rd_n`=1, the outputs are unchanged.
- R4: With RD_MODE=0 (combinational), `rdata` equals the word at `raddr` with no clock involved.
- R5: With WR_MODE=1 (asynchronous), a word is written at the rising edge of `wr_n`, using the `waddr`, `wdata` and `wpar` present at that edge. `wclk` has no effect.
- R6: PAR_MODE=3 (check even) and PAR_MODE=4 (check odd) store `wpar` beside the word. A write is wrong when the XOR of all data bits and `wpar` is not 0 (even) or not 1 (odd). With synchronous writes, `wr_perr` is 1 for the `wclk` cycle after a wrong write and 0 otherwise. With asynchronous writes, it is 1 while `wr_n`=0 and the presented word is wrong.
- R7: In check modes, `rd_perr` is 1 exactly when the word being shown fails the same parity rule, using its stored data and stored bit. It follows the same timing as `rdata`. It is 0 before the first read after reset (registered modes) and while `rd_n`=1 (combinational mode).
- R8: PAR_MODE=1 (generate even) and PAR_MODE=2 (generate odd) store XOR(data) XOR (1 for odd, 0 for even). `wpar` is ignored. In these modes `rd_perr` and `wr_perr` stay 0.
- R9: PAR_MODE=0 (none) drives `rpar`, `wr_perr` and `rd_perr` to 0.
- R10: Reset is synchronous and active high on each clock. It clears both error flags, the read address register, and (pipelined) `rdata` and `rpar` to 0. It does not clear the array.
- R11: In check and generate modes, `rpar` shows the parity bit stored with the word on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock, rising edge |
| rclk | input | 1 | Read clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| wr_n | input | 1 | Active-low write strobe |
| waddr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| wpar | input | 1 | Parity bit supplied with the write data (check modes) |
| rd_n | input | 1 | Active-low read strobe |
| raddr | input | ADDR_W | Read address |
| rdata | output | DATA_W | Read data |
| rpar | output | 1 | Stored parity bit of the shown word |
| wr_perr | output | 1 | Parity error detected on write |
| rd_perr | output | 1 | Parity error detected on the shown word |

## Verification
The bench compares every output against a behavioural model while writes land on the word held by the transparent address register. A design that latched data instead of the address would show stale words there. It drops the read strobe for runs of cycles on the pipelined variant; a design that advanced its pipeline regardless would change its output. Words written with deliberately wrong parity are read back to confirm the read flag comes from the stored bit: a block that regenerated parity at read time would never flag them. On the asynchronous-write variant, the address and data are held across the rising strobe edge and changed only afterwards, which exposes a design that captures at the falling edge.

// File: rtl/dcram_pkg.sv
`timescale 1ns/100ps
package dcram_pkg;

    typedef enum logic [1:0] {
        RD_COMB = 2'd0,
        RD_XPAR = 2'd1,
        RD_PIPE = 2'd2
    } rd_mode_e;

    typedef enum logic {
        WR_SYNC  = 1'b0,
        WR_ASYNC = 1'b1
    } wr_mode_e;

    typedef enum logic [2:0] {
        PAR_NONE     = 3'd0,
        PAR_GEN_EVEN = 3'd1,
        PAR_GEN_ODD  = 3'd2,
        PAR_CHK_EVEN = 3'd3,
        PAR_CHK_ODD  = 3'd4
    } par_mode_e;

    function automatic logic par_is_check(par_mode_e m);
        return (m == PAR_CHK_EVEN) || (m == PAR_CHK_ODD);
    endfunction

    function automatic logic par_is_gen(par_mode_e m);
        return (m == PAR_GEN_EVEN) || (m == PAR_GEN_ODD);
    endfunction

    // value the XOR of data and parity bit must reach
    function automatic logic par_goal(par_mode_e m);
        return (m == PAR_GEN_ODD) || (m == PAR_CHK_ODD);
    endfunction

    function automatic logic par_kept(par_mode_e m);
        return m != PAR_NONE;
    endfunction

    function automatic int unsigned addr_bits(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dcram_wr_side.sv
`timescale 1ns/100ps
module dcram_wr_side
    import dcram_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter wr_mode_e    WR_MODE  = WR_SYNC,
    parameter par_mode_e   PAR_MODE = PAR_CHK_EVEN
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wpar,
    output logic              keep_bit,
    output logic              wr_perr
);
    localparam logic CHK  = par_is_check(PAR_MODE);
    localparam logic GEN  = par_is_gen(PAR_MODE);
    localparam logic GOAL = par_goal(PAR_MODE);

    logic word_bad;

    assign word_bad = CHK && ((^wdata ^ wpar) != GOAL);

    // bit stored beside the word
    always_comb begin
        if (GEN)      keep_bit = ^wdata ^ GOAL;
        else if (CHK) keep_bit = wpar;
        else          keep_bit = 1'b0;
    end

    generate
        if (WR_MODE == WR_SYNC) begin : g_sync
            logic perr_q;
            always_ff @(posedge wclk) begin
                if (rst) perr_q <= 1'b0;
                else     perr_q <= !wr_n && word_bad;
            end
            assign wr_perr = perr_q;

            AST_WPERR_AFTER_WRITE: assert property (@(posedge wclk) disable iff (rst)
                wr_perr |-> $past(!wr_n))
                else $error("write flag without a write"); // R6
        end else begin : g_async
            assign wr_perr = !wr_n && word_bad;
        end
    endgenerate

endmodule

// File: rtl/dcram_store.sv
`timescale 1ns/100ps
module dcram_store
    import dcram_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned WORDS   = 16,
    parameter int unsigned ADDR_W  = 4,
    parameter wr_mode_e    WR_MODE = WR_SYNC
) (
    input  logic              wclk,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(WORDS);

    typedef struct packed {
        logic              chk;
        logic [DATA_W-1:0] val;
    } cell_t;

    cell_t mem [WORDS];
    cell_t wcell;
    cell_t rcell;
    logic  w_in_range;

    assign wcell      = '{chk: wbit, val: wdata};
    assign w_in_range = {1'b0, waddr} < LIMIT;

    generate
        if (WR_MODE == WR_SYNC) begin : g_sync
            always_ff @(posedge wclk) begin
                if (!wr_n && w_in_range) mem[waddr] <= wcell;
            end
        end else begin : g_async
            // word taken when the strobe returns high
            always_ff @(posedge wr_n) begin
                if (w_in_range) mem[waddr] <= wcell;
            end
        end
    endgenerate

    assign rcell   = ({1'b0, rd_addr} < LIMIT) ? mem[rd_addr] : '0;
    assign rd_data = rcell.val;
    assign rd_bit  = rcell.chk;

endmodule

// File: rtl/dcram_rd_side.sv
`timescale 1ns/100ps
module dcram_rd_side
    import dcram_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter rd_mode_e    RD_MODE  = RD_XPAR,
    parameter par_mode_e   PAR_MODE = PAR_CHK_EVEN
) (
    input  logic              rclk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] cell_data,
    input  logic              cell_bit,
    output logic [ADDR_W-1:0] cell_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rpar,
    output logic              rd_perr
);
    localparam logic CHK  = par_is_check(PAR_MODE);
    localparam logic GEN  = par_is_gen(PAR_MODE);
    localparam logic GOAL = par_goal(PAR_MODE);
    localparam logic KEEP = par_kept(PAR_MODE);

    logic cell_bad;
    logic shown_bit;
    logic shown_vld;

    assign cell_bad  = CHK && ((^cell_data ^ cell_bit) != GOAL);
    assign shown_bit = KEEP ? cell_bit : 1'b0;

    generate
        if (RD_MODE == RD_COMB) begin : g_comb
            assign cell_addr = raddr;
            assign rdata     = cell_data;
            assign rpar      = shown_bit;
            assign rd_perr   = !rd_n && cell_bad;
            assign shown_vld = !rd_n;
        end else if (RD_MODE == RD_XPAR) begin : g_xpar
            logic [ADDR_W-1:0] addr_q;
            logic              seen_q;
            always_ff @(posedge rclk) begin
                if (rst) begin
                    addr_q <= '0;
                    seen_q <= 1'b0;
                end else if (!rd_n) begin
                    addr_q <= raddr;
                    seen_q <= 1'b1;
                end
            end
            assign cell_addr = addr_q;
            assign rdata     = cell_data;
            assign rpar      = shown_bit;
            assign rd_perr   = seen_q && cell_bad;
            assign shown_vld = seen_q;

            AST_XPAR_ADDR_HOLD: assert property (@(posedge rclk) disable iff (rst)
                rd_n |=> $stable(addr_q))
                else $error("address moved without a read"); // R2
        end else begin : g_pipe
            logic [ADDR_W-1:0] addr_q;
            logic              pend_q;
            logic [DATA_W-1:0] data_q;
            logic              bit_q;
            logic              perr_q;
            logic              full_q;
            always_ff @(posedge rclk) begin
                if (rst) begin
                    addr_q <= '0;
                    pend_q <= 1'b0;
                    data_q <= '0;
                    bit_q  <= 1'b0;
                    perr_q <= 1'b0;
                    full_q <= 1'b0;
                end else begin
                    pend_q <= !rd_n;
                    if (!rd_n) addr_q <= raddr;
                    if (pend_q) begin
                        data_q <= cell_data;
                        bit_q  <= shown_bit;
                        perr_q <= cell_bad;
                        full_q <= 1'b1;
                    end
                end
            end
            assign cell_addr = addr_q;
            assign rdata     = data_q;
            assign rpar      = bit_q;
            assign rd_perr   = perr_q;
            assign shown_vld = full_q;

            AST_PIPE_ADDR_HOLD: assert property (@(posedge rclk) disable iff (rst)
                rd_n |=> $stable(addr_q))
                else $error("pipe address moved without a read"); // R3
            AST_PIPE_OUT_HOLD: assert property (@(posedge rclk) disable iff (rst)
                rd_n |-> ##2 $stable(rdata))
                else $error("pipe output moved without a read"); // R3
        end
    endgenerate

    AST_RD_FLAG_AGREES: assert property (@(posedge rclk) disable iff (rst)
        (CHK && shown_vld) |-> (rd_perr == ((^rdata ^ rpar) != GOAL)))
        else $error("read flag disagrees with shown word"); // R7
    AST_GEN_WORD_GOOD: assert property (@(posedge rclk) disable iff (rst)
        (GEN && shown_vld) |-> (((^rdata ^ rpar) == GOAL) && !rd_perr))
        else $error("generated parity wrong on read"); // R8

endmodule

// File: rtl/dcram_par.sv
`timescale 1ns/100ps
module dcram_par
    import dcram_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned WORDS    = 16,
    parameter rd_mode_e    RD_MODE  = RD_XPAR,
    parameter wr_mode_e    WR_MODE  = WR_SYNC,
    parameter par_mode_e   PAR_MODE = PAR_CHK_EVEN,
    localparam int unsigned ADDR_W  = addr_bits(WORDS)
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wpar,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rpar,
    output logic              rd_perr,
    output logic              wr_perr
);
    logic              keep_bit;
    logic [ADDR_W-1:0] cell_addr;
    logic [DATA_W-1:0] cell_data;
    logic              cell_bit;

    dcram_wr_side #(
        .DATA_W   (DATA_W),
        .WR_MODE  (WR_MODE),
        .PAR_MODE (PAR_MODE)
    ) u_wr (
        .wclk     (wclk),
        .rst      (rst),
        .wr_n     (wr_n),
        .wdata    (wdata),
        .wpar     (wpar),
        .keep_bit (keep_bit),
        .wr_perr  (wr_perr)
    );

    dcram_store #(
        .DATA_W  (DATA_W),
        .WORDS   (WORDS),
        .ADDR_W  (ADDR_W),
        .WR_MODE (WR_MODE)
    ) u_store (
        .wclk    (wclk),
        .wr_n    (wr_n),
        .waddr   (waddr),
        .wdata   (wdata),
        .wbit    (keep_bit),
        .rd_addr (cell_addr),
        .rd_data (cell_data),
        .rd_bit  (cell_bit)
    );

    dcram_rd_side #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RD_MODE  (RD_MODE),
        .PAR_MODE (PAR_MODE)
    ) u_rd (
        .rclk      (rclk),
        .rst       (rst),
        .rd_n      (rd_n),
        .raddr     (raddr),
        .cell_data (cell_data),
        .cell_bit  (cell_bit),
        .cell_addr (cell_addr),
        .rdata     (rdata),
        .rpar      (rpar),
        .rd_perr   (rd_perr)
    );

endmodule

// File: tb/test_dcram_par.sv
`timescale 1ns/100ps
module test_dcram_par;
    import dcram_pkg::*;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    logic rst  = 1'b1;

    // shared stimulus for the synchronous-write instances
    logic       wr_n  = 1'b1;
    logic [3:0] waddr = '0;
    logic [7:0] wdata = '0;
    logic       wpar  = 1'b0;
    logic       rd_n  = 1'b1;
    logic [3:0] raddr = '0;
    // stimulus for the asynchronous-write instance
    logic       wr_n_a  = 1'b1;
    logic [3:0] waddr_a = '0;
    logic [7:0] wdata_a = '0;
    logic       wpar_a  = 1'b0;

    logic [7:0] x_rdata, p_rdata, n_rdata, c_rdata;
    logic       x_rpar, p_rpar, n_rpar, c_rpar;
    logic       x_rpe, p_rpe, n_rpe, c_rpe;
    logic       x_wpe, p_wpe, n_wpe, c_wpe;

    int total = 0;
    int bad   = 0;
    logic started = 1'b0;
    logic fill_s = 1'b0;
    logic fill_a = 1'b0;

    always #2.5 wclk = ~wclk;   // 200 MHz write clock
    always #3.5 rclk = ~rclk;

    // transparent read, sync write, check even
    dcram_par i_dcram_par (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_n(wr_n), .waddr(waddr),
        .wdata(wdata), .wpar(wpar), .rd_n(rd_n), .raddr(raddr),
        .rdata(x_rdata), .rpar(x_rpar), .rd_perr(x_rpe), .wr_perr(x_wpe));

    dcram_par #(.RD_MODE(RD_PIPE), .PAR_MODE(PAR_GEN_ODD)) u_pipe (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_n(wr_n), .waddr(waddr),
        .wdata(wdata), .wpar(wpar), .rd_n(rd_n), .raddr(raddr),
        .rdata(p_rdata), .rpar(p_rpar), .rd_perr(p_rpe), .wr_perr(p_wpe));

    dcram_par #(.RD_MODE(RD_PIPE), .PAR_MODE(PAR_NONE)) u_none (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_n(wr_n), .waddr(waddr),
        .wdata(wdata), .wpar(wpar), .rd_n(rd_n), .raddr(raddr),
        .rdata(n_rdata), .rpar(n_rpar), .rd_perr(n_rpe), .wr_perr(n_wpe));

    dcram_par #(.RD_MODE(RD_COMB), .WR_MODE(WR_ASYNC), .PAR_MODE(PAR_CHK_ODD)) u_comb (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_n(wr_n_a), .waddr(waddr_a),
        .wdata(wdata_a), .wpar(wpar_a), .rd_n(rd_n), .raddr(raddr),
        .rdata(c_rdata), .rpar(c_rpar), .rd_perr(c_rpe), .wr_perr(c_wpe));

    // ---------------- reference model ----------------
    logic [7:0] m_data [16];
    logic       m_wpar [16];
    logic       wperr_m = 1'b0;
    logic [7:0] a_data [16];
    logic       a_par  [16];
    logic       a_wr   [16];
    logic [3:0] x_addr = '0;
    logic       x_vld  = 1'b0;
    logic [3:0] q_addr = '0;
    logic       q_pend = 1'b0;
    logic [7:0] q_data = '0;
    logic       q_par  = 1'b0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_data[i] = '0; m_wpar[i] = 1'b0;
            a_data[i] = '0; a_par[i] = 1'b0; a_wr[i] = 1'b0;
        end
    end

    always @(posedge wclk) begin
        if (rst) wperr_m = 1'b0;
        else begin
            wperr_m = !wr_n && ((^wdata ^ wpar) != 1'b0);
            if (!wr_n) begin
                m_data[waddr] = wdata;
                m_wpar[waddr] = wpar;
            end
        end
    end

    always @(posedge wr_n_a) begin
        a_data[waddr_a] = wdata_a;
        a_par[waddr_a]  = wpar_a;
        a_wr[waddr_a]   = 1'b1;
    end

    always @(posedge rclk) begin
        if (rst) begin
            x_addr = '0; x_vld = 1'b0;
            q_addr = '0; q_pend = 1'b0; q_data = '0; q_par = 1'b0;
        end else begin
            if (q_pend) begin
                q_data = m_data[q_addr];
                q_par  = ~(^m_data[q_addr]);
            end
            if (!rd_n) begin
                x_addr = raddr; x_vld = 1'b1; q_addr = raddr;
            end
            q_pend = !rd_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        // transparent, check even
        if (x_vld) begin
            chk("R1 R2 rdata", 32'(x_rdata), 32'(m_data[x_addr]));
            chk("R11 rpar", 32'(x_rpar), 32'(m_wpar[x_addr]));
            chk("R7 rd_perr", 32'(x_rpe), 32'((^m_data[x_addr] ^ m_wpar[x_addr]) != 1'b0));
        end else begin
            chk("R7 rd_perr before read", 32'(x_rpe), 32'd0);
        end
        chk("R6 wr_perr", 32'(x_wpe), 32'(wperr_m));
        // pipelined, generate odd
        chk("R3 pipe rdata", 32'(p_rdata), 32'(q_data));
        chk("R8 gen rpar", 32'(p_rpar), 32'(q_par));
        chk("R8 gen rd_perr", 32'(p_rpe), 32'd0);
        chk("R8 gen wr_perr", 32'(p_wpe), 32'd0);
        // pipelined, no parity
        chk("R3 none rdata", 32'(n_rdata), 32'(q_data));
        chk("R9 none rpar", 32'(n_rpar), 32'd0);
        chk("R9 none rd_perr", 32'(n_rpe), 32'd0);
        chk("R9 none wr_perr", 32'(n_wpe), 32'd0);
        // combinational read, async write, check odd
        if (a_wr[raddr]) begin
            chk("R4 R5 comb rdata", 32'(c_rdata), 32'(a_data[raddr]));
            chk("R11 comb rpar", 32'(c_rpar), 32'(a_par[raddr]));
            chk("R7 comb rd_perr", 32'(c_rpe),
                32'(!rd_n && ((^a_data[raddr] ^ a_par[raddr]) != 1'b1)));
        end
        chk("R6 async wr_perr", 32'(c_wpe),
            32'(!wr_n_a && ((^wdata_a ^ wpar_a) != 1'b1)));
    endtask

    // sample between edges: negedges fall on whole ns, posedges on half ns
    always @(negedge wclk or negedge rclk) begin
        #0.4;
        if (started) compare_all();
    end

    // ---------------- stimulus ----------------
    task automatic writer_sync();
        for (int i = 0; i < 16; i++) begin
            @(negedge wclk);
            wr_n  = 1'b0;
            waddr = 4'(i);
            wdata = 8'(i * 37 + 5);
            wpar  = (i % 4 == 3) ? ~(^wdata) : ^wdata;
        end
        @(negedge wclk) wr_n = 1'b1;
        fill_s = 1'b1;
        for (int i = 0; i < 1500; i++) begin
            @(negedge wclk);
            wr_n  = ($urandom_range(0, 2) == 0) ? 1'b0 : 1'b1;
            waddr = 4'($urandom);
            wdata = 8'($urandom);
            wpar  = 1'($urandom);
        end
        @(negedge wclk) wr_n = 1'b1;
    endtask

    task automatic write_async(input logic [3:0] a, input logic [7:0] d, input logic p);
        @(negedge wclk);
        waddr_a = a; wdata_a = d; wpar_a = p; wr_n_a = 1'b0;
        @(negedge wclk) wr_n_a = 1'b1;
        @(negedge wclk);
        waddr_a = 4'($urandom); wdata_a = 8'($urandom);
    endtask

    task automatic writer_async();
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            d = 8'(i * 11 + 3);
            write_async(4'(i), d, (i % 3 == 0) ? (^d) : ~(^d));
        end
        fill_a = 1'b1;
        for (int i = 0; i < 300; i++)
            write_async(4'($urandom), 8'($urandom), 1'($urandom));
    endtask

    task automatic reader();
        wait (fill_s && fill_a);
        for (int i = 0; i < 1200; i++) begin
            @(negedge rclk);
            if (i % 100 < 6) rd_n = 1'b1;   // held-strobe bursts, address keeps moving
            else rd_n = ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0;
            raddr = 4'($urandom);
        end
        @(negedge rclk) rd_n = 1'b1;
    endtask

    initial begin
        repeat (6) @(posedge rclk);
        @(negedge wclk) rst = 1'b0;
        #0.4;
        chk("R10 wr_perr after reset", 32'(x_wpe), 32'd0);
        chk("R10 rd_perr after reset", 32'(x_rpe), 32'd0);
        chk("R10 pipe rdata after reset", 32'(p_rdata), 32'd0);
        chk("R10 pipe rpar after reset", 32'(p_rpar), 32'd0);
        started = 1'b1;
        fork
            writer_sync();
            writer_async();
            reader();
        join
        repeat (10) @(posedge rclk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule